// File: doc/BRIEF.md
# Clause 22 MDIO Management Controller

This block lets a processor reach the management registers of Ethernet PHYs through one 32-bit command/status word. Software writes a single word that carries the target PHY address, the register number within that PHY, a read/write selector and, for writes, the 16-bit value. The controller accepts the word, raises a busy flag and shifts out a complete Clause 22 management frame on MDC/MDIO. MDC comes from the system clock through a parameterised divider. MDC stays low whenever no frame is in flight.

A write command needs no further attention from software. It can issue the next command once busy drops. For a read, the controller releases MDIO from the turnaround onward and samples the PHY's reply on each rising MDC edge. When the frame ends, it places the 16 received bits in the low half of the same word and sets a read-valid flag. If the PHY never pulls the second turnaround bit low, the read finishes with read-valid clear, so an absent device can be told apart from a good reply. A command written while busy is set is dropped and the frame in flight is not disturbed.

Top module: `mdio_c22_ctrl`

## Requirements
- R1: The readable word carries data in bits 15:0, the PHY address in bits 20:16, the register number in bits 25:21 and the operation in bit 26 (1 = read, 0 = write). All of these fields take their values from the last accepted command word.
- R2: Busy (bit 28) is 1 from the cycle after a command is accepted until the frame completes. A frame lasts exactly 128 × DIV_HALF system cycles.
- R3: Every frame starts with 32 ones and then start bits 0,1. Next come opcode 1,0 for a read or 0,1 for a write, then the 5-bit PHY address and the 5-bit register number. All fields are sent MSB first.
- R4: A write frame drives turnaround 1,0 and then the 16 write-data bits MSB first, with MDIO enabled for all 64 bits.
- R5: A read frame drives the first 46 bits and releases MDIO (output enable low) for the 2 turnaround bits and the 16 data bits. On completion, read-valid (bit 27) is 1 and bits 15:0 hold the 16 bits sampled on the MDC rising edges, MSB first.
- R6: Read-valid is 0 while busy is 1, and it stays 0 after a write completes.
- R7: If MDIO is high when sampled during the second turnaround bit of a read, read-valid stays 0 after the frame completes.
- R8: A command written while busy is 1 is ignored. The fields in bits 26:16 do not change, and the frame on the wire and the result are those of the earlier command.
- R9: MDC and the MDIO output enable are low whenever busy is 0. MDC has a period of 2 × DIV_HALF system cycles. The MDIO output and output enable change only while MDC is low.
- R10: After reset the readable word is 0, and MDC and the output enable are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Command word: data, PHY address, register, operation |
| reg_rdata | output | 32 | Status word: data, fields, read-valid, busy |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven by the controller |
| mdio_oe | output | 1 | MDIO output enable (1 = controller drives) |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The assertions check the following on every cycle:
- Busy rises after an accepted command.
- The command fields hold steady while busy is set.
- Read-valid is never set during busy, and is set only for a read.
- MDC and the output enable are idle whenever the controller is not busy.
- The MDIO output and output enable change only while MDC is low.

Only the bench scenarios can show the bit order of the frame, the exact frame length and MDC period, and the release of MDIO during the read turnaround. They also cover the data captured from a modelled PHY, the missing-turnaround case from an absent address, and a command dropped in the middle of a frame.

// File: rtl/mdio_c22_pkg.sv
package mdio_c22_pkg;

    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_IDX     = FRAME_BITS - DATA_W - 2;
    localparam int DATA_IDX   = FRAME_BITS - DATA_W;

    localparam int DATA_LSB   = 0;
    localparam int PA_LSB     = 16;
    localparam int RA_LSB     = 21;
    localparam int OP_BIT     = 26;
    localparam int RVALID_BIT = 27;
    localparam int BUSY_BIT   = 28;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } mdio_op_e;

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input mdio_op_e          op,
        input logic [ADDR_W-1:0] pa,
        input logic [ADDR_W-1:0] ra,
        input logic [DATA_W-1:0] wd
    );
        logic [1:0]        opc;
        logic [1:0]        ta;
        logic [DATA_W-1:0] dat;
        opc = (op == OP_READ) ? 2'b10 : 2'b01;
        ta  = (op == OP_READ) ? 2'b11 : 2'b10;
        dat = (op == OP_READ) ? {DATA_W{1'b1}} : wd;
        return {{PRE_BITS{1'b1}}, 2'b01, opc, pa, ra, ta, dat};
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);

    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] TERM = CW'(DIV_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    term;

    always_comb begin
        st_d     = st_q;
        term     = run && (st_q.cnt == TERM);
        rise_stb = term && !st_q.mdc;
        fall_stb = term && st_q.mdc;
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (term) begin
            st_d.cnt = '0;
            st_d.mdc = !st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mdc = st_q.mdc;

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_c22_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  mdio_op_e          go_op,
    input  logic [ADDR_W-1:0] go_pa,
    input  logic [ADDR_W-1:0] go_ra,
    input  logic [DATA_W-1:0] go_wdata,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              active,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              ta_ok
);

    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA2_IDX   = IDX_W'(TA_IDX + 1);
    localparam logic [IDX_W-1:0] REL_IDX   = IDX_W'(TA_IDX);
    localparam logic [IDX_W-1:0] FIRST_DAT = IDX_W'(DATA_IDX);

    typedef struct packed {
        logic                  active;
        mdio_op_e              op;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sh;
        logic [DATA_W-1:0]     rdata;
        logic                  ta_ok;
    } eng_st_t;

    eng_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (!st_q.active) begin
            if (go) begin
                st_d.active = 1'b1;
                st_d.op     = go_op;
                st_d.idx    = '0;
                st_d.sh     = build_frame(go_op, go_pa, go_ra, go_wdata);
                st_d.rdata  = '0;
                st_d.ta_ok  = 1'b0;
            end
        end else begin
            // sample on the MDC rising edge
            if (rise_stb && (st_q.op == OP_READ)) begin
                if (st_q.idx == TA2_IDX) begin
                    st_d.ta_ok = !mdio_i;
                end else if (st_q.idx >= FIRST_DAT) begin
                    st_d.rdata = {st_q.rdata[DATA_W-2:0], mdio_i};
                end
            end
            // advance on the MDC falling edge
            if (fall_stb) begin
                st_d.sh = {st_q.sh[FRAME_BITS-2:0], 1'b1};
                if (st_q.idx == LAST_IDX) begin
                    st_d.active = 1'b0;
                    done        = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active  = st_q.active;
    assign mdio_o  = st_q.active & st_q.sh[FRAME_BITS-1];
    assign mdio_oe = st_q.active && !((st_q.op == OP_READ) && (st_q.idx >= REL_IDX));
    assign rd_data = st_q.rdata;
    assign ta_ok   = st_q.ta_ok;

endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
    import mdio_c22_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              ta_ok,
    output logic [31:0]       reg_rdata,
    output logic              go,
    output mdio_op_e          go_op,
    output logic [ADDR_W-1:0] go_pa,
    output logic [ADDR_W-1:0] go_ra,
    output logic [DATA_W-1:0] go_wdata
);

    typedef struct packed {
        logic              busy;
        logic              rvalid;
        mdio_op_e          op;
        logic [ADDR_W-1:0] pa;
        logic [ADDR_W-1:0] ra;
        logic [DATA_W-1:0] data;
    } cmd_st_t;

    cmd_st_t st_d, st_q;
    logic    unused_hi;

    assign unused_hi = ^reg_wdata[31:OP_BIT+1];

    assign go_op    = mdio_op_e'(reg_wdata[OP_BIT]);
    assign go_pa    = reg_wdata[PA_LSB +: ADDR_W];
    assign go_ra    = reg_wdata[RA_LSB +: ADDR_W];
    assign go_wdata = reg_wdata[DATA_LSB +: DATA_W];

    always_comb begin
        st_d = st_q;
        go   = reg_wr && !st_q.busy;
        if (go) begin
            st_d.busy   = 1'b1;
            st_d.rvalid = 1'b0;
            st_d.op     = go_op;
            st_d.pa     = go_pa;
            st_d.ra     = go_ra;
            st_d.data   = go_wdata;
        end else if (done) begin
            st_d.busy = 1'b0;
            if ((st_q.op == OP_READ) && ta_ok) begin
                st_d.rvalid = 1'b1;
                st_d.data   = rd_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata                          = '0;
        reg_rdata[DATA_LSB +: DATA_W]      = st_q.data;
        reg_rdata[PA_LSB +: ADDR_W]        = st_q.pa;
        reg_rdata[RA_LSB +: ADDR_W]        = st_q.ra;
        reg_rdata[OP_BIT]                  = st_q.op;
        reg_rdata[RVALID_BIT]              = st_q.rvalid;
        reg_rdata[BUSY_BIT]                = st_q.busy;
    end

endmodule

// File: rtl/mdio_c22_ctrl.sv
module mdio_c22_ctrl
    import mdio_c22_pkg::*;
#(
    parameter int DIV_HALF = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic              go;
    mdio_op_e          go_op;
    logic [ADDR_W-1:0] go_pa;
    logic [ADDR_W-1:0] go_ra;
    logic [DATA_W-1:0] go_wdata;
    logic              active;
    logic              rise_stb;
    logic              fall_stb;
    logic              done;
    logic [DATA_W-1:0] rd_data;
    logic              ta_ok;

    mdio_cmd_reg u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .done      (done),
        .rd_data   (rd_data),
        .ta_ok     (ta_ok),
        .reg_rdata (reg_rdata),
        .go        (go),
        .go_op     (go_op),
        .go_pa     (go_pa),
        .go_ra     (go_ra),
        .go_wdata  (go_wdata)
    );

    mdio_clkdiv #(
        .DIV_HALF (DIV_HALF)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (active),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_eng u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .go_op    (go_op),
        .go_pa    (go_pa),
        .go_ra    (go_ra),
        .go_wdata (go_wdata),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .active   (active),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rd_data  (rd_data),
        .ta_ok    (ta_ok)
    );

endmodule

// File: rtl/mdio_c22_chk.sv
module mdio_c22_chk
    import mdio_c22_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [31:0] reg_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);

    logic busy;
    logic rvalid;
    assign busy   = reg_rdata[BUSY_BIT];
    assign rvalid = reg_rdata[RVALID_BIT];

    p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !busy) |=> busy);

    p_fields_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(reg_rdata[OP_BIT:PA_LSB]));

    p_rvalid_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rvalid);

    p_rvalid_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> reg_rdata[OP_BIT]);

    p_idle_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    p_drive_low_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

endmodule

bind mdio_c22_ctrl mdio_c22_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_c22_ctrl_bench.sv
module mdio_c22_ctrl_bench;
    import mdio_c22_pkg::*;

    localparam int          DH     = 4;
    localparam logic [4:0]  PHY_PA = 5'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    int phy_cnt = 0;

    logic [15:0] phy_mem [32];
    logic [15:0] exp_mem [32];
    logic        fr_bit  [64];
    logic        fr_oe   [64];

    mdio_c22_ctrl #(.DIV_HALF(DH)) u_mdio_c22_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] seed_val(int i);
        return 16'hA500 ^ (16'(i) * 16'h0313);
    endfunction

    function automatic logic [15:0] fr_field(int first, int n);
        logic [15:0] v = '0;
        for (int k = 0; k < n; k++) v = {v[14:0], fr_bit[first + k]};
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            summary();
            $finish;
        end
    end

    // PHY model: record each bit on the MDC rising edge
    always @(posedge mdc) begin
        fr_bit[phy_cnt] = mdio_o;
        fr_oe[phy_cnt]  = mdio_oe;
        if (phy_cnt == 63) begin
            if (fr_field(34, 2) == 16'd1 && fr_field(36, 5) == 16'(PHY_PA))
                phy_mem[fr_field(41, 5)] = fr_field(48, 16);
            phy_cnt = 0;
        end else begin
            phy_cnt++;
        end
    end

    // PHY model: drive the reply after the MDC falling edge
    always @(negedge mdc) begin
        if (phy_cnt >= 46 && fr_field(34, 2) == 16'd2 && fr_field(36, 5) == 16'(PHY_PA)) begin
            if (phy_cnt == 46)      mdio_i = 1'b1;
            else if (phy_cnt == 47) mdio_i = 1'b0;
            else                    mdio_i = phy_mem[fr_field(41, 5)][63 - phy_cnt];
        end else begin
            mdio_i = 1'b1;
        end
    end

    task automatic issue(input logic op, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = {5'b0, op, ra, pa, wd};
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (reg_rdata[BUSY_BIT]) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_frame(input logic op, input logic [4:0] pa, input logic [4:0] ra,
                               input logic [15:0] wd);
        int ones = 0;
        int oe_bad = 0;
        for (int k = 0; k < 32; k++) ones += int'(fr_bit[k]);
        chk("R3 preamble ones", 32'(ones), 32'd32);
        chk("R3 start bits", 32'(fr_field(32, 2)), 32'd1);
        chk("R3 opcode", 32'(fr_field(34, 2)), op ? 32'd2 : 32'd1);
        chk("R3 phy address", 32'(fr_field(36, 5)), 32'(pa));
        chk("R3 register number", 32'(fr_field(41, 5)), 32'(ra));
        if (!op) begin
            for (int k = 0; k < 64; k++) if (!fr_oe[k]) oe_bad++;
            chk("R4 turnaround", 32'(fr_field(46, 2)), 32'd2);
            chk("R4 write data", 32'(fr_field(48, 16)), 32'(wd));
            chk("R4 drive enable", 32'(oe_bad), 32'd0);
        end else begin
            for (int k = 0; k < 64; k++) if (fr_oe[k] != (k < 46)) oe_bad++;
            chk("R5 release pattern", 32'(oe_bad), 32'd0);
        end
    endtask

    task automatic run_op(input logic op, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] wd);
        int n;
        issue(op, pa, ra, wd);
        chk("R1 fields", {5'b0, reg_rdata[26:16]}, {5'b0, op, ra, pa});
        chk("R6 rvalid while busy", 32'(reg_rdata[RVALID_BIT]), 32'd0);
        wait_idle(n);
        chk("R2 busy length", 32'(n), 32'(128 * DH));
        check_frame(op, pa, ra, wd);
        if (!op) begin
            chk("R6 rvalid after write", 32'(reg_rdata[RVALID_BIT]), 32'd0);
            chk("R1 write data", 32'(reg_rdata[15:0]), 32'(wd));
            if (pa == PHY_PA) exp_mem[ra] = wd;
        end else if (pa == PHY_PA) begin
            chk("R5 rvalid", 32'(reg_rdata[RVALID_BIT]), 32'd1);
            chk("R5 read data", 32'(reg_rdata[15:0]), 32'(exp_mem[ra]));
        end else begin
            chk("R7 no turnaround", 32'(reg_rdata[RVALID_BIT]), 32'd0);
        end
    endtask

    initial begin
        int t0;
        int n;
        logic [31:0] seed;
        for (int i = 0; i < 32; i++) begin
            phy_mem[i] = seed_val(i);
            exp_mem[i] = seed_val(i);
        end
        repeat (4) @(negedge clk);
        chk("R10 word after reset", reg_rdata, 32'h0);
        chk("R10 mdc after reset", 32'(mdc), 32'd0);
        chk("R10 oe after reset", 32'(mdio_oe), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 mdc idle", 32'(mdc), 32'd0);

        // directed write then read back
        run_op(1'b0, PHY_PA, 5'd5, 16'hBEEF);
        run_op(1'b1, PHY_PA, 5'd5, 16'h0000);
        chk("R5 full word", reg_rdata, {3'b0, 1'b0, 1'b1, 1'b1, 5'd5, PHY_PA, 16'hBEEF});

        // MDC period
        issue(1'b1, PHY_PA, 5'd9, 16'h0);
        @(posedge mdc);
        t0 = cyc;
        @(posedge mdc);
        chk("R9 mdc period", 32'(cyc - t0), 32'(2 * DH));
        wait_idle(n);
        chk("R5 second read", 32'(reg_rdata[15:0]), 32'(exp_mem[9]));

        // absent PHY
        run_op(1'b1, 5'd17, 5'd2, 16'h0);

        // command during busy is dropped
        issue(1'b1, PHY_PA, 5'd7, 16'h0);
        repeat (100) @(negedge clk);
        issue(1'b0, 5'd12, 5'd30, 16'h1234);
        chk("R8 fields kept", {5'b0, reg_rdata[26:16]}, {5'b0, 1'b1, 5'd7, PHY_PA});
        wait_idle(n);
        check_frame(1'b1, PHY_PA, 5'd7, 16'h0);
        chk("R8 result of first", {reg_rdata[27], reg_rdata[15:0]}, {1'b1, exp_mem[7]});
        run_op(1'b1, PHY_PA, 5'd30, 16'h0);
        chk("R8 no write landed", 32'(reg_rdata[15:0]), 32'(seed_val(30)));

        // random traffic
        seed = $urandom(32'd2024);
        for (int i = 0; i < 24; i++) begin
            logic op;
            logic [4:0] pa, ra;
            logic [15:0] wd;
            op = 1'($urandom % 2);
            pa = ($urandom % 4 == 0) ? 5'($urandom) : PHY_PA;
            ra = 5'($urandom);
            wd = 16'($urandom);
            run_op(op, pa, ra, wd);
        end

        summary();
        $finish;
    end

endmodule